// File: doc/BRIEF.md
# Banked Register File with Movable Bank Pointer

This block holds the general registers of a 32-bit controller core. The storage is split into several banks of four registers each, plus a separate fixed set of four registers that does not move with the banks. The last fixed register serves as the stack pointer and is always visible on its own output. A bank pointer chooses the current bank. The instruction decoder changes the pointer with a hold, load, increment or decrement operation. Each operand names a register relative to that pointer: in the current bank, in the bank just below it (for code written for an alternate register set), in a bank given by number, or in the fixed set.

Each access chooses a view of its register: a single byte lane, a 16-bit half or the whole word. Writes replace only the bytes in the chosen view. Reads return the chosen view zero-extended to the full width. The block has two combinational read ports and one write port. The write port and the pointer update take effect at the clock edge, so a read in the same cycle still sees the old contents and the old pointer.

Top module: `rf_banked`

## Requirements
- R1: While rst_n is low, and after its release, every register reads zero, sp_o is zero and bank_ptr_o is zero.
- R2: Operand select encoding: 0 = current bank (bank_ptr_o), 1 = previous bank, 2 = the bank given in the operand's bank field, 3 = fixed set. The idx field picks one of the four registers in the chosen bank or set.
- R3: The previous bank is bank_ptr_o minus one, modulo the bank count. With the pointer at 0, select 1 reaches bank 3.
- R4: Pointer operation encoding: 0 = hold, 1 = load ptr_val_i, 2 = increment, 3 = decrement, with increment and decrement wrapping modulo the bank count. The new value appears after the clock edge. Operands in the same cycle use the old pointer.
- R5: Size encoding: 0 = byte, with lane number part; 1 = half, with part[1] choosing upper (1) or lower (0); 2 or 3 = full word. A byte write takes wr_data_i[7:0] and a half write takes wr_data_i[15:0]. All other bytes of the register keep their value.
- R6: A byte or half read returns the selected bits in the low end of the read data, with all higher bits zero. A word read returns the whole register.
- R7: A read of the register being written in the same cycle returns its old value. The new value is readable from the next cycle on.
- R8: sp_o always shows fixed register 3, and a write to that register shows on sp_o one cycle later.
- R9: The two read ports are independent and both produce their result in the same cycle as their address.
- R10: With we_i low, no register changes, whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_op_i | input | 2 | Bank pointer operation (R4 encoding) |
| ptr_val_i | input | 2 | Value used by a pointer load |
| rda_sel_i | input | 2 | Read port A operand select |
| rda_bank_i | input | 2 | Read port A bank number for select 2 |
| rda_idx_i | input | 2 | Read port A register in bank or fixed set |
| rda_size_i | input | 2 | Read port A access size |
| rda_part_i | input | 2 | Read port A lane or half |
| rda_data_o | output | 32 | Read port A zero-extended data |
| rdb_sel_i | input | 2 | Read port B operand select |
| rdb_bank_i | input | 2 | Read port B bank number for select 2 |
| rdb_idx_i | input | 2 | Read port B register in bank or fixed set |
| rdb_size_i | input | 2 | Read port B access size |
| rdb_part_i | input | 2 | Read port B lane or half |
| rdb_data_o | output | 32 | Read port B zero-extended data |
| we_i | input | 1 | Write enable |
| wr_sel_i | input | 2 | Write operand select |
| wr_bank_i | input | 2 | Write bank number for select 2 |
| wr_idx_i | input | 2 | Write register in bank or fixed set |
| wr_size_i | input | 2 | Write access size |
| wr_part_i | input | 2 | Write lane or half |
| wr_data_i | input | 32 | Write data, low bits used for sub-word writes |
| bank_ptr_o | output | 2 | Current bank pointer |
| sp_o | output | 32 | Stack pointer (fixed register 3) |

## Verification
Read data depends only on the current inputs, the stored values and the pointer, so read results are due in the same cycle as their address. The bench checks them a nanosecond after driving, well before the next rising edge. Writes and pointer operations are due one edge later. The reference model applies them only after that rising edge, and the next comparison happens at the following falling edge. This means every same-cycle read is compared against the old register contents and the old pointer.

// File: rtl/rf_banked_pkg.sv
package rf_banked_pkg;

   typedef enum logic [1:0] {
      SEL_CUR  = 2'd0,
      SEL_PREV = 2'd1,
      SEL_ABS  = 2'd2,
      SEL_FIX  = 2'd3
   } rf_sel_e;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_WORDX = 2'd3
   } rf_size_e;

   typedef enum logic [1:0] {
      PTR_HOLD = 2'd0,
      PTR_LOAD = 2'd1,
      PTR_INC  = 2'd2,
      PTR_DEC  = 2'd3
   } rf_ptr_op_e;

endpackage

// File: rtl/rf_addr_resolve.sv
module rf_addr_resolve
   import rf_banked_pkg::*;
#(
   parameter int NUM_BANKS     = 4,
   parameter int REGS_PER_BANK = 4,
   parameter int FIXED_REGS    = 4,
   parameter int BANK_W        = $clog2(NUM_BANKS),
   parameter int IDX_W         = $clog2(REGS_PER_BANK),
   parameter int FLAT_W        = $clog2(NUM_BANKS * REGS_PER_BANK + FIXED_REGS)
) (
   input  logic [1:0]        sel_i,
   input  logic [BANK_W-1:0] bank_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [BANK_W-1:0] ptr_i,
   output logic [FLAT_W-1:0] flat_o
);

   localparam int BANK_REGS = NUM_BANKS * REGS_PER_BANK;

   logic [BANK_W-1:0] prev_bank;
   logic [BANK_W-1:0] bank_sel;

   // bank count is a power of two, so the subtraction wraps by itself
   assign prev_bank = ptr_i - BANK_W'(1);

   always_comb begin
      case (rf_sel_e'(sel_i))
         SEL_CUR:  bank_sel = ptr_i;
         SEL_PREV: bank_sel = prev_bank;
         SEL_ABS:  bank_sel = bank_i;
         default:  bank_sel = ptr_i;
      endcase
   end

   always_comb begin
      if (rf_sel_e'(sel_i) == SEL_FIX)
         flat_o = FLAT_W'(BANK_REGS) + FLAT_W'(idx_i);
      else
         flat_o = FLAT_W'(bank_sel) * FLAT_W'(REGS_PER_BANK) + FLAT_W'(idx_i);
   end

endmodule

// File: rtl/rf_lane_merge.sv
module rf_lane_merge
   import rf_banked_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LANES  = DATA_W / 8,
   parameter int PART_W = $clog2(DATA_W / 8)
) (
   input  logic [DATA_W-1:0] old_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [1:0]        size_i,
   input  logic [PART_W-1:0] part_i,
   output logic [DATA_W-1:0] merged_o
);

   localparam int HALF_LANES = LANES / 2;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic       hit;
      logic [7:0] src;

      always_comb begin
         case (rf_size_e'(size_i))
            SZ_BYTE: begin
               hit = (part_i == PART_W'(l));
               src = wdata_i[7:0];
            end
            SZ_HALF: begin
               hit = (part_i[PART_W-1] == 1'(l / HALF_LANES));
               src = wdata_i[8*(l % HALF_LANES) +: 8];
            end
            default: begin
               hit = 1'b1;
               src = wdata_i[8*l +: 8];
            end
         endcase
      end

      assign merged_o[8*l +: 8] = hit ? src : old_i[8*l +: 8];
   end

endmodule

// File: rtl/rf_read_extract.sv
module rf_read_extract
   import rf_banked_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int PART_W = $clog2(DATA_W / 8)
) (
   input  logic [DATA_W-1:0] reg_i,
   input  logic [1:0]        size_i,
   input  logic [PART_W-1:0] part_i,
   output logic [DATA_W-1:0] data_o
);

   localparam int HALF_W = DATA_W / 2;

   logic [7:0]        byte_v;
   logic [HALF_W-1:0] half_v;

   assign byte_v = reg_i[{part_i, 3'b000} +: 8];
   assign half_v = part_i[PART_W-1] ? reg_i[DATA_W-1:HALF_W] : reg_i[HALF_W-1:0];

   always_comb begin
      case (rf_size_e'(size_i))
         SZ_BYTE: data_o = {{(DATA_W-8){1'b0}}, byte_v};
         SZ_HALF: data_o = {{HALF_W{1'b0}}, half_v};
         default: data_o = reg_i;
      endcase
   end

endmodule

// File: rtl/rf_banked.sv
module rf_banked
   import rf_banked_pkg::*;
#(
   parameter int NUM_BANKS     = 4,
   parameter int REGS_PER_BANK = 4,
   parameter int FIXED_REGS    = 4,
   parameter int DATA_W        = 32,
   parameter int SP_IDX        = FIXED_REGS - 1,
   parameter int BANK_W        = $clog2(NUM_BANKS),
   parameter int IDX_W         = $clog2(REGS_PER_BANK),
   parameter int PART_W        = $clog2(DATA_W / 8)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        ptr_op_i,
   input  logic [BANK_W-1:0] ptr_val_i,
   input  logic [1:0]        rda_sel_i,
   input  logic [BANK_W-1:0] rda_bank_i,
   input  logic [IDX_W-1:0]  rda_idx_i,
   input  logic [1:0]        rda_size_i,
   input  logic [PART_W-1:0] rda_part_i,
   output logic [DATA_W-1:0] rda_data_o,
   input  logic [1:0]        rdb_sel_i,
   input  logic [BANK_W-1:0] rdb_bank_i,
   input  logic [IDX_W-1:0]  rdb_idx_i,
   input  logic [1:0]        rdb_size_i,
   input  logic [PART_W-1:0] rdb_part_i,
   output logic [DATA_W-1:0] rdb_data_o,
   input  logic              we_i,
   input  logic [1:0]        wr_sel_i,
   input  logic [BANK_W-1:0] wr_bank_i,
   input  logic [IDX_W-1:0]  wr_idx_i,
   input  logic [1:0]        wr_size_i,
   input  logic [PART_W-1:0] wr_part_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [BANK_W-1:0] bank_ptr_o,
   output logic [DATA_W-1:0] sp_o
);

   localparam int BANK_REGS = NUM_BANKS * REGS_PER_BANK;
   localparam int TOTAL     = BANK_REGS + FIXED_REGS;
   localparam int FLAT_W    = $clog2(TOTAL);

   // elaboration-time parameter checks
   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_chk_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (REGS_PER_BANK < 2 || (REGS_PER_BANK & (REGS_PER_BANK - 1)) != 0) begin : g_chk_regs
      $error("REGS_PER_BANK must be a power of two of at least 2");
   end
   if (FIXED_REGS != REGS_PER_BANK) begin : g_chk_fixed
      $error("FIXED_REGS must equal REGS_PER_BANK so one idx field serves both");
   end
   if (DATA_W < 16 || (DATA_W & (DATA_W - 1)) != 0) begin : g_chk_width
      $error("DATA_W must be a power of two of at least 16");
   end
   if (SP_IDX < 0 || SP_IDX >= FIXED_REGS) begin : g_chk_sp
      $error("SP_IDX must address a fixed register");
   end

   logic [DATA_W-1:0] rf_q [TOTAL];
   logic [BANK_W-1:0] ptr_q;
   logic [FLAT_W-1:0] a_flat, b_flat, w_flat;
   logic [DATA_W-1:0] w_merged;

   rf_addr_resolve #(
      .NUM_BANKS(NUM_BANKS), .REGS_PER_BANK(REGS_PER_BANK), .FIXED_REGS(FIXED_REGS),
      .BANK_W(BANK_W), .IDX_W(IDX_W), .FLAT_W(FLAT_W)
   ) u_res_a (
      .sel_i(rda_sel_i), .bank_i(rda_bank_i), .idx_i(rda_idx_i),
      .ptr_i(ptr_q), .flat_o(a_flat)
   );

   rf_addr_resolve #(
      .NUM_BANKS(NUM_BANKS), .REGS_PER_BANK(REGS_PER_BANK), .FIXED_REGS(FIXED_REGS),
      .BANK_W(BANK_W), .IDX_W(IDX_W), .FLAT_W(FLAT_W)
   ) u_res_b (
      .sel_i(rdb_sel_i), .bank_i(rdb_bank_i), .idx_i(rdb_idx_i),
      .ptr_i(ptr_q), .flat_o(b_flat)
   );

   rf_addr_resolve #(
      .NUM_BANKS(NUM_BANKS), .REGS_PER_BANK(REGS_PER_BANK), .FIXED_REGS(FIXED_REGS),
      .BANK_W(BANK_W), .IDX_W(IDX_W), .FLAT_W(FLAT_W)
   ) u_res_w (
      .sel_i(wr_sel_i), .bank_i(wr_bank_i), .idx_i(wr_idx_i),
      .ptr_i(ptr_q), .flat_o(w_flat)
   );

   rf_read_extract #(.DATA_W(DATA_W), .PART_W(PART_W)) u_ext_a (
      .reg_i(rf_q[a_flat]), .size_i(rda_size_i), .part_i(rda_part_i), .data_o(rda_data_o)
   );

   rf_read_extract #(.DATA_W(DATA_W), .PART_W(PART_W)) u_ext_b (
      .reg_i(rf_q[b_flat]), .size_i(rdb_size_i), .part_i(rdb_part_i), .data_o(rdb_data_o)
   );

   rf_lane_merge #(.DATA_W(DATA_W), .PART_W(PART_W)) u_merge (
      .old_i(rf_q[w_flat]), .wdata_i(wr_data_i), .size_i(wr_size_i),
      .part_i(wr_part_i), .merged_o(w_merged)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < TOTAL; i++) rf_q[i] <= '0;
      end else if (we_i) begin
         rf_q[w_flat] <= w_merged;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else begin
         case (rf_ptr_op_e'(ptr_op_i))
            PTR_LOAD: ptr_q <= ptr_val_i;
            PTR_INC:  ptr_q <= ptr_q + BANK_W'(1);
            PTR_DEC:  ptr_q <= ptr_q - BANK_W'(1);
            default:  ptr_q <= ptr_q;
         endcase
      end
   end

   assign bank_ptr_o = ptr_q;
   assign sp_o       = rf_q[BANK_REGS + SP_IDX];

endmodule

// File: rtl/rf_banked_chk.sv
module rf_banked_chk #(
   parameter int DATA_W = 32,
   parameter int BANK_W = 2,
   parameter int IDX_W  = 2,
   parameter int SP_IDX = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        ptr_op_i,
   input logic [BANK_W-1:0] ptr_val_i,
   input logic [BANK_W-1:0] bank_ptr_o,
   input logic              we_i,
   input logic [1:0]        wr_sel_i,
   input logic [IDX_W-1:0]  wr_idx_i,
   input logic [1:0]        wr_size_i,
   input logic [DATA_W-1:0] wr_data_i,
   input logic [DATA_W-1:0] sp_o,
   input logic [1:0]        rda_size_i,
   input logic [DATA_W-1:0] rda_data_o,
   input logic [1:0]        rdb_size_i,
   input logic [DATA_W-1:0] rdb_data_o
);

   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_op_i == 2'd0) |=> $stable(bank_ptr_o)); // R4
   AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_op_i == 2'd1) |=> (bank_ptr_o == $past(ptr_val_i))); // R4
   AST_PTR_INC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_op_i == 2'd2) |=> (bank_ptr_o == BANK_W'($past(bank_ptr_o) + BANK_W'(1)))); // R4
   AST_PTR_DEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_op_i == 2'd3) |=> (bank_ptr_o == BANK_W'($past(bank_ptr_o) - BANK_W'(1)))); // R4
   AST_RDA_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (rda_size_i == 2'd0) |-> (rda_data_o[DATA_W-1:8] == '0)); // R6
   AST_RDB_HALF_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (rdb_size_i == 2'd1) |-> (rdb_data_o[DATA_W-1:DATA_W/2] == '0)); // R6
   AST_SP_WORD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && wr_sel_i == 2'd3 && wr_idx_i == IDX_W'(SP_IDX) && wr_size_i[1])
      |=> (sp_o == $past(wr_data_i))); // R8
   AST_SP_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(sp_o)); // R10

endmodule

bind rf_banked rf_banked_chk #(
   .DATA_W(DATA_W), .BANK_W(BANK_W), .IDX_W(IDX_W), .SP_IDX(SP_IDX)
) u_rf_banked_chk (
   .clk(clk), .rst_n(rst_n), .ptr_op_i(ptr_op_i), .ptr_val_i(ptr_val_i),
   .bank_ptr_o(bank_ptr_o), .we_i(we_i), .wr_sel_i(wr_sel_i), .wr_idx_i(wr_idx_i),
   .wr_size_i(wr_size_i), .wr_data_i(wr_data_i), .sp_o(sp_o),
   .rda_size_i(rda_size_i), .rda_data_o(rda_data_o),
   .rdb_size_i(rdb_size_i), .rdb_data_o(rdb_data_o)
);

// File: tb/test_rf_banked.sv
`timescale 1ns/1ps
module test_rf_banked;

   localparam int NB = 4;
   localparam int RPB = 4;
   localparam int NREG = NB * RPB + 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  ptr_op_i = '0, ptr_val_i = '0;
   logic [1:0]  rda_sel_i = '0, rda_bank_i = '0, rda_idx_i = '0, rda_size_i = '0, rda_part_i = '0;
   logic [1:0]  rdb_sel_i = '0, rdb_bank_i = '0, rdb_idx_i = '0, rdb_size_i = '0, rdb_part_i = '0;
   logic [31:0] rda_data_o, rdb_data_o, sp_o;
   logic        we_i = 1'b0;
   logic [1:0]  wr_sel_i = '0, wr_bank_i = '0, wr_idx_i = '0, wr_size_i = '0, wr_part_i = '0;
   logic [31:0] wr_data_i = '0;
   logic [1:0]  bank_ptr_o;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [31:0] m_reg [NREG];
   int          m_ptr = 0;

   always #2 clk = ~clk;

   rf_banked i_rf_banked (
      .clk(clk), .rst_n(rst_n), .ptr_op_i(ptr_op_i), .ptr_val_i(ptr_val_i),
      .rda_sel_i(rda_sel_i), .rda_bank_i(rda_bank_i), .rda_idx_i(rda_idx_i),
      .rda_size_i(rda_size_i), .rda_part_i(rda_part_i), .rda_data_o(rda_data_o),
      .rdb_sel_i(rdb_sel_i), .rdb_bank_i(rdb_bank_i), .rdb_idx_i(rdb_idx_i),
      .rdb_size_i(rdb_size_i), .rdb_part_i(rdb_part_i), .rdb_data_o(rdb_data_o),
      .we_i(we_i), .wr_sel_i(wr_sel_i), .wr_bank_i(wr_bank_i), .wr_idx_i(wr_idx_i),
      .wr_size_i(wr_size_i), .wr_part_i(wr_part_i), .wr_data_i(wr_data_i),
      .bank_ptr_o(bank_ptr_o), .sp_o(sp_o)
   );

   function automatic int m_slot(input int sel, input int bank, input int idx);
      case (sel)
         0: return m_ptr * RPB + idx;
         1: return ((m_ptr + NB - 1) % NB) * RPB + idx;
         2: return bank * RPB + idx;
         default: return NB * RPB + idx;
      endcase
   endfunction

   function automatic logic [31:0] m_view(input logic [31:0] v, input int size, input int part);
      if (size == 0) return (v >> (8 * part)) & 32'hFF;
      if (size == 1) return (v >> (16 * (part / 2))) & 32'hFFFF;
      return v;
   endfunction

   function automatic logic [31:0] m_merge(input logic [31:0] o, input logic [31:0] w,
                                           input int size, input int part);
      logic [31:0] mask;
      if (size == 0) begin
         mask = 32'hFF << (8 * part);
         return (o & ~mask) | ((w & 32'hFF) << (8 * part));
      end
      if (size == 1) begin
         mask = 32'hFFFF << (16 * (part / 2));
         return (o & ~mask) | ((w & 32'hFFFF) << (16 * (part / 2)));
      end
      return w;
   endfunction

   task automatic check(input string tag, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // compare at 1 ns after drive, then let the edge happen and advance the model
   task automatic step(input string tag);
      int slot;
      #1;
      check(tag, "rda", rda_data_o,
            m_view(m_reg[m_slot(rda_sel_i, rda_bank_i, rda_idx_i)], rda_size_i, rda_part_i));
      check(tag, "rdb", rdb_data_o,
            m_view(m_reg[m_slot(rdb_sel_i, rdb_bank_i, rdb_idx_i)], rdb_size_i, rdb_part_i));
      check(tag, "sp", sp_o, m_reg[NB * RPB + 3]);
      check(tag, "ptr", {30'd0, bank_ptr_o}, 32'(m_ptr));
      @(posedge clk);
      if (rst_n) begin
         slot = m_slot(wr_sel_i, wr_bank_i, wr_idx_i);
         if (we_i) m_reg[slot] = m_merge(m_reg[slot], wr_data_i, wr_size_i, wr_part_i);
         case (ptr_op_i)
            2'd1: m_ptr = ptr_val_i;
            2'd2: m_ptr = (m_ptr + 1) % NB;
            2'd3: m_ptr = (m_ptr + NB - 1) % NB;
            default: ;
         endcase
      end
      @(negedge clk);
   endtask

   task automatic rd_a(input int sel, input int bank, input int idx, input int size, input int part);
      rda_sel_i = 2'(sel); rda_bank_i = 2'(bank); rda_idx_i = 2'(idx);
      rda_size_i = 2'(size); rda_part_i = 2'(part);
   endtask

   task automatic rd_b(input int sel, input int bank, input int idx, input int size, input int part);
      rdb_sel_i = 2'(sel); rdb_bank_i = 2'(bank); rdb_idx_i = 2'(idx);
      rdb_size_i = 2'(size); rdb_part_i = 2'(part);
   endtask

   task automatic wr(input bit en, input int sel, input int bank, input int idx, input int size,
                     input int part, input logic [31:0] data);
      we_i = en; wr_sel_i = 2'(sel); wr_bank_i = 2'(bank); wr_idx_i = 2'(idx);
      wr_size_i = 2'(size); wr_part_i = 2'(part); wr_data_i = data;
   endtask

   task automatic ptr(input int op, input int val);
      ptr_op_i = 2'(op); ptr_val_i = 2'(val);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NREG; i++) m_reg[i] = '0;
      @(negedge clk);
      // R1: reset state
      wr(1, 2, 1, 1, 2, 0, 32'hDEAD_BEEF);
      ptr(1, 2);
      step("R1");
      step("R1");
      wr(0, 0, 0, 0, 2, 0, 0); ptr(0, 0);
      rst_n = 1'b1;
      for (int i = 0; i < NREG; i++) begin
         rd_a(i < 16 ? 2 : 3, (i / 4) % 4, i % 4, 2, 0);
         rd_b(i < 16 ? 2 : 3, (i / 4) % 4, i % 4, 2, 0);
         step("R1");
      end
      // R2: fill each bank by absolute number, read back through every select
      for (int b = 0; b < NB; b++)
         for (int r = 0; r < RPB; r++) begin
            wr(1, 2, b, r, 2, 0, 32'h1000_0000 * (b + 1) + 32'h0101 * (r + 1));
            step("R2");
         end
      wr(0, 0, 0, 0, 0, 0, 0);
      for (int r = 0; r < 4; r++) begin
         wr(1, 3, 0, r, 2, 0, 32'hF000_0000 + 32'(r)); step("R8");
      end
      wr(0, 0, 0, 0, 0, 0, 0);
      rd_a(0, 0, 2, 2, 0); rd_b(3, 0, 1, 2, 0); step("R2");
      // R3: previous bank wraps from 0 to the top bank
      rd_a(1, 0, 0, 2, 0); rd_b(1, 0, 3, 2, 0); step("R3");
      check("R3", "prev bank 3 reg 0", rda_data_o, 32'h4000_0101);
      // R4: load, increment wrap, decrement wrap; same-cycle operands use old pointer
      ptr(1, 3); rd_a(0, 0, 1, 2, 0); step("R4");
      ptr(2, 0); rd_a(0, 0, 1, 2, 0); step("R4");
      ptr(3, 0); rd_a(1, 0, 1, 2, 0); step("R4");
      ptr(0, 0); step("R4");
      check("R4", "ptr after dec wrap", {30'd0, bank_ptr_o}, 32'd3);
      ptr(2, 0); step("R4"); ptr(0, 0); step("R4");
      check("R4", "ptr after inc wrap", {30'd0, bank_ptr_o}, 32'd0);
      // R5: sub-word writes touch only their bytes
      wr(1, 2, 1, 2, 0, 2, 32'hFFFF_FFAB); rd_a(2, 1, 2, 2, 0); step("R5");
      wr(1, 2, 1, 2, 1, 2, 32'hFFFF_1234); step("R5");
      wr(1, 2, 1, 2, 1, 0, 32'h0000_5678); step("R5");
      wr(1, 2, 1, 2, 0, 0, 32'h0000_00CD); step("R5");
      wr(0, 0, 0, 0, 0, 0, 0); step("R5");
      check("R5", "merged word", rda_data_o, 32'h1234_56CD);
      // R6: zero-extended views on both ports
      rd_a(2, 1, 2, 0, 3); rd_b(2, 1, 2, 1, 2); step("R6");
      rd_a(2, 1, 2, 0, 1); rd_b(2, 1, 2, 1, 1); step("R6");
      check("R6", "byte lane 1", rda_data_o, 32'h0000_0056);
      // R7: read during write returns old value, new value next cycle
      wr(1, 0, 0, 0, 2, 0, 32'hCAFE_0007); rd_a(0, 0, 0, 2, 0); rd_b(2, 0, 0, 2, 0); step("R7");
      wr(0, 0, 0, 0, 0, 0, 0); step("R7");
      check("R7", "new value", rda_data_o, 32'hCAFE_0007);
      // R8: stack pointer write visible one cycle later
      wr(1, 3, 0, 3, 2, 0, 32'h0000_8000); step("R8");
      wr(0, 0, 0, 0, 0, 0, 0); step("R8");
      check("R8", "sp", sp_o, 32'h0000_8000);
      // R9: independent ports in the same cycle
      rd_a(3, 0, 3, 1, 0); rd_b(2, 3, 3, 0, 3); step("R9");
      // R10: disabled write changes nothing
      wr(0, 3, 0, 3, 2, 0, 32'h1111_1111); rd_a(3, 0, 3, 2, 0); step("R10");
      wr(0, 2, 1, 2, 2, 0, 32'h2222_2222); rd_a(2, 1, 2, 2, 0); step("R10");
      step("R10");
      // mixed stimulus against the model
      for (int n = 0; n < 4000; n++) begin
         ptr(($urandom % 4 == 0) ? int'($urandom % 4) : 0, int'($urandom % 4));
         rd_a(int'($urandom % 4), int'($urandom % 4), int'($urandom % 4),
              int'($urandom % 4), int'($urandom % 4));
         rd_b(int'($urandom % 4), int'($urandom % 4), int'($urandom % 4),
              int'($urandom % 4), int'($urandom % 4));
         wr(($urandom % 2) == 1, int'($urandom % 4), int'($urandom % 4), int'($urandom % 4),
            int'($urandom % 4), int'($urandom % 4), $urandom);
         step("R2");
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule